// File: doc/BRIEF.md
# Urgency-Arbitrated Two-Register Transfer Unit

The block keeps two small counters, an upper register (X) and a lower register (Y), and lets three independent requesters change them. A bump request adds one to X. A move request takes one unit out of X and puts it into Y, both in the same clock edge. A drain request takes one unit from Y. Each requester raises a condition input, and the block answers in the same cycle with a fired flag that says whether its update is committed at the coming clock edge.

The move shares X with the bump and Y with the drain, so it can never take effect together with either of them. A fixed urgency order settles each cycle: drain beats move, and move beats bump. Bump and drain touch different registers and go ahead together whenever nothing more urgent blocks them. A request that does not fire is simply not applied. The requester holds its condition and retries. Both registers wrap around on overflow and underflow.

Top module: `urgency_xfer_unit`

## Requirements
- R1: While rst_n is low, x_val and y_val are 0 and all three fired outputs are 0. The registers stay 0 at the first edge after release when no request is raised.
- R2: A bump request alone asserts bump_fired, and x_val rises by one at the next clock edge. y_val does not change.
- R3: A move request alone asserts move_fired. At the next edge x_val falls by one and y_val rises by one, in the same edge.
- R4: A drain request alone asserts drain_fired, and y_val falls by one at the next edge. x_val does not change.
- R5: When drain and move are both requested, only drain fires. x_val is unchanged and y_val falls by one.
- R6: When move and bump are both requested, only move fires. The bump is not applied in that cycle.
- R7: When bump and drain are both requested without move, both fire in the same cycle. x_val rises by one and y_val falls by one.
- R8: When all three are requested, bump and drain fire and move is suppressed.
- R9: Both registers are 8 bits wide and wrap: 255 plus one gives 0, and 0 minus one gives 255.
- R10: A fired output is never high without its request. With no request, both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bump_req | input | 1 | Request to add one to X |
| move_req | input | 1 | Request to move one unit from X to Y |
| drain_req | input | 1 | Request to subtract one from Y |
| bump_fired | output | 1 | Bump committed at the coming edge |
| move_fired | output | 1 | Move committed at the coming edge |
| drain_fired | output | 1 | Drain committed at the coming edge |
| x_val | output | W | Current value of X |
| y_val | output | W | Current value of Y |

## Verification
Bump and drain are the only two operations that may commit in the same cycle, because they write different registers. The bench provokes this by raising bump and drain together, and again by raising all three requests at once, where move must step aside. Each such cycle is judged on two things: both fired flags must be high with move_fired low, and at the following edge X must gain exactly one while Y loses exactly one.

// File: rtl/urgency_xfer_unit.sv
module urgency_xfer_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump_req,
  input  logic         move_req,
  input  logic         drain_req,
  output logic         bump_fired,
  output logic         move_fired,
  output logic         drain_fired,
  output logic [W-1:0] x_val,
  output logic [W-1:0] y_val
);

  localparam logic [W-1:0] ONE = W'(1);

  assign drain_fired = rst_n & drain_req;
  assign move_fired  = rst_n & move_req & ~drain_req;
  assign bump_fired  = rst_n & bump_req & ~move_fired;

  logic [W-1:0] x_nxt, y_nxt;

  always_comb begin
    x_nxt = x_val;
    y_nxt = y_val;
    if (bump_fired)  x_nxt = x_val + ONE;
    if (move_fired) begin
      x_nxt = x_val - ONE;
      y_nxt = y_val + ONE;
    end
    if (drain_fired) y_nxt = y_val - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_val <= '0;
      y_val <= '0;
    end else begin
      x_val <= x_nxt;
      y_val <= y_nxt;
    end
  end

endmodule

// File: rtl/urgency_xfer_unit_chk.sv
module urgency_xfer_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bump_req,
  input logic         move_req,
  input logic         drain_req,
  input logic         bump_fired,
  input logic         move_fired,
  input logic         drain_fired,
  input logic [W-1:0] x_val,
  input logic [W-1:0] y_val
);

  always_comb begin
    if (!rst_n) assert_quiet_in_reset_R1: assert (!bump_fired && !move_fired && !drain_fired);
  end

  assert_fired_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bump_fired |-> bump_req) and (move_fired |-> move_req) and (drain_fired |-> drain_req));

  assert_drain_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req |-> (drain_fired && !move_fired));

  assert_move_over_bump_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (move_req && !drain_req) |-> (move_fired && !bump_fired));

  assert_bump_with_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bump_req && drain_req) |-> (bump_fired && drain_fired));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bump_fired && !move_fired && !drain_fired) |=> ($stable(x_val) && $stable(y_val)));

  assert_move_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    move_fired |=> (x_val == W'($past(x_val) - 1'b1)) && (y_val == W'($past(y_val) + 1'b1)));

  assert_bump_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bump_fired |=> (x_val == W'($past(x_val) + 1'b1)));

  assert_drain_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_fired && !move_fired) |=> (y_val == W'($past(y_val) - 1'b1)));

endmodule

bind urgency_xfer_unit urgency_xfer_unit_chk #(.W(W)) chk (.*);

// File: tb/urgency_xfer_unit_test.sv
`timescale 1ns/1ps
module urgency_xfer_unit_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bump_req = 1'b0, move_req = 1'b0, drain_req = 1'b0;
  logic bump_fired, move_fired, drain_fired;
  logic [7:0] x_val, y_val;

  always #2 clk = ~clk;

  urgency_xfer_unit #(.W(8)) uut (
    .clk(clk), .rst_n(rst_n),
    .bump_req(bump_req), .move_req(move_req), .drain_req(drain_req),
    .bump_fired(bump_fired), .move_fired(move_fired), .drain_fired(drain_fired),
    .x_val(x_val), .y_val(y_val)
  );

  typedef struct packed {
    logic [2:0] f;
    logic [7:0] x;
    logic [7:0] y;
  } exp_t;

  exp_t  sb_q[$];
  string tag_q[$];
  int    checks = 0;
  int    fails  = 0;
  logic  [7:0] mx = 8'd0, my = 8'd0;
  bit    drive_done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic m, input logic d, input string tag);
    logic ed, em, eb;
    exp_t e;
    @(negedge clk);
    bump_req = b; move_req = m; drain_req = d;
    ed = d;
    em = m & ~d;
    eb = b & ~em;
    if (eb) mx = mx + 8'd1;
    if (em) begin mx = mx - 8'd1; my = my + 8'd1; end
    if (ed) my = my - 8'd1;
    e.f = {eb, em, ed};
    e.x = mx;
    e.y = my;
    sb_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        string t;
        e = sb_q.pop_front();
        t = tag_q.pop_front();
        check({bump_fired, move_fired, drain_fired} == e.f, t, "fired{b,m,d}",
              {13'd0, bump_fired, move_fired, drain_fired}, {13'd0, e.f});
        check(x_val == e.x && y_val == e.y, t, "{x,y}", {x_val, y_val}, {e.x, e.y});
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    bump_req = 1'b1; move_req = 1'b1; drain_req = 1'b1;
    #0.5;
    check(x_val == 8'd0 && y_val == 8'd0, "R1", "reset {x,y}", {x_val, y_val}, 16'd0);
    check({bump_fired, move_fired, drain_fired} == 3'b000, "R1", "reset fired",
          {13'd0, bump_fired, move_fired, drain_fired}, 16'd0);
    @(negedge clk);
    bump_req = 1'b0; move_req = 1'b0; drain_req = 1'b0;
    rst_n = 1'b1;
    step(0, 0, 0, "R1");
    step(1, 0, 0, "R2");
    step(1, 0, 0, "R2");
    step(1, 0, 0, "R2");
    step(0, 1, 0, "R3");
    step(0, 0, 1, "R4");
    step(0, 0, 0, "R10");
    step(0, 1, 1, "R5");
    step(1, 1, 0, "R6");
    step(1, 0, 1, "R7");
    step(1, 1, 1, "R8");
    step(1, 1, 1, "R8");
    step(0, 1, 0, "R3");
    for (int i = 0; i < 4; i++) step(0, 0, 1, "R9");
    for (int i = 0; i < 256; i++) step(1, 0, 0, "R9");
    step(0, 1, 1, "R5");
    step(1, 1, 0, "R6");
    step(0, 0, 0, "R10");
    @(negedge clk);
    bump_req = 1'b0; move_req = 1'b0; drain_req = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    drive_done = 1'b1;
  end

  initial begin
    fork
      wait (drive_done && sb_q.size() == 0);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule